// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM with a two-stage pipeline. Address, operation and byte-lane enables are captured on a rising clock edge. The matching data phase follows two clock cycles later, for reads and for writes alike. Because a write's data also trails its command by two cycles, reads and writes can be issued in any order on consecutive cycles and the data bus never needs an idle slot to turn around.

A command is either a load, which starts a new operation at a new address, or an advance, which steps an internal 4-beat burst counter from the last loaded address. A static input picks linear or interleaved beat order. Three chip selects gate new loads, but they never cancel transfers already in the pipeline. A stall input freezes the whole block. An asynchronous drive-off input forces the read bus idle at any moment.

The bus has no back-pressure and no valid/ready handshake. The stall input is the only way to hold the flow, and it holds every stage at once. Read data is given as a separate output with a drive flag, which stands in for a tri-state pin. While the flag is low the output reads as zero.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at enabled edge N drives `rdata_oe` high, with that word on `rdata`, for the whole cycle that follows enabled edge N+1. That is the second cycle after the command cycle. At all other times the read bus is undriven.
- R2: For a write command sampled at enabled edge N, the write data is taken from `wdata` at enabled edge N+2.
- R3: Reads and writes can be issued on consecutive cycles in any mix. A read always returns the bytes of every write issued before it, including a write issued one or two cycles earlier.
- R4: While `stall` is high at an edge, every input is ignored and all pipeline, burst and storage state holds. The outputs stay unchanged until the next enabled edge.
- R5: `burst_next`=0 is a load and `burst_next`=1 is an advance. With `order_ilv`=0, beat k (k=0..3) of a burst uses the loaded address with its two low bits replaced by (low bits + k) mod 4. The upper bits and the operation stay those of the load.
- R6: With `order_ilv`=1, beat k uses the two low bits XOR k.
- R7: A load starts an operation only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Otherwise no operation starts, and transfers already issued still complete.
- R8: A deselected load, and any advance that follows it, starts no transfer. The read bus stays undriven in the matching data slots.
- R9: `lane_wr_n` is active low and is sampled with each command or beat. Bit i enables byte lane i, which is `wdata[8i+7:8i]`. Lanes that are not enabled keep their stored value.
- R10: `drive_off`=1 forces `rdata_oe` low and `rdata` to zero at once, without waiting for a clock. Clearing it restores the pending read data within the same cycle.
- R11: During and right after reset, no operation is pending and the read bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| stall | input | 1 | 1 freezes the whole block for that edge |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 loads a new command, 1 advances the burst |
| op_read | input | 1 | On a load: 1 read, 0 write |
| lane_wr_n | input | LANES | Active-low byte lane write enables |
| addr | input | ADDR_W | Word address, used on loads |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| drive_off | input | 1 | Asynchronous read bus disable |
| wdata | input | LANES*8 | Write data, sampled in the data cycle |
| rdata | output | LANES*8 | Read data; zero while not driven |
| rdata_oe | output | 1 | High while `rdata` carries read data |

## Verification
Errors in the burst counter or the stored base address show up as a wrong word on the first advanced beat that reaches its data slot, two cycles after the bad beat was issued. A wrong pipeline valid or operation bit makes the bus drive in an empty slot or stay silent in a read slot, and this is visible in the cycle the data was due. Missing write-to-read forwarding, a bad byte-lane merge, or a frozen stage that moves under stall all show up as stale or shifted read data at the next read of that address. The bench runs a behavioural model alongside the design and compares the drive flag and the data on every cycle, so each of these faults is reported in the first slot where it becomes visible.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  // Low address bits of a burst beat: wrapping add or XOR with the beat count.
  function automatic logic [BEAT_W-1:0] beat_lo(input logic [BEAT_W-1:0] start,
                                                input logic [BEAT_W-1:0] n,
                                                input logic              ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/zbt_cmd_seq.sv
module zbt_cmd_seq
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              chip_sel,
  input  logic              burst_next,
  input  logic              op_read,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_ilv,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_lane_n,
  output logic              burst_act,
  output logic [BEAT_W-1:0] beat_cnt
);
  logic [ADDR_W-1:0] base_q;
  logic              op_wr_q;
  logic [BEAT_W-1:0] nxt_cnt;

  assign nxt_cnt = beat_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      beat_cnt  <= '0;
      base_q    <= '0;
      op_wr_q   <= 1'b0;
      s1_vld    <= 1'b0;
      s1_wr     <= 1'b0;
      s1_addr   <= '0;
      s1_lane_n <= '1;
    end else if (en) begin
      s1_lane_n <= lane_wr_n;
      if (!burst_next) begin
        burst_act <= chip_sel;
        base_q    <= addr;
        beat_cnt  <= '0;
        op_wr_q   <= !op_read;
        s1_vld    <= chip_sel;
        s1_wr     <= !op_read;
        s1_addr   <= addr;
      end else begin
        s1_vld <= burst_act;
        if (burst_act) begin
          beat_cnt <= nxt_cnt;
          s1_wr    <= op_wr_q;
          s1_addr  <= {base_q[ADDR_W-1:BEAT_W],
                       beat_lo(base_q[BEAT_W-1:0], nxt_cnt, order_ilv)};
        end
      end
    end
  end
endmodule

// File: rtl/zbt_lane_store.sv
module zbt_lane_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    wr_vld,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_vld,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic same_word;
  assign same_word = wr_vld && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    logic              wr_this;
    assign wr_this = wr_vld && !wr_lane_n[g];

    always_ff @(posedge clk) begin
      if (en) begin
        if (wr_this) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        // A read in the same edge as a write to its word sees the new byte.
        if (rd_vld) q <= (same_word && !wr_lane_n[g]) ? wdata[g*LANE_W +: LANE_W]
                                                       : mem[rd_addr];
      end
    end
    assign rd_data[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              burst_next,
  input  logic              op_read,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_ilv,
  input  logic              drive_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              en;
  logic              chip_sel;
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lane_n;
  logic              burst_act;
  logic [BEAT_W-1:0] beat_cnt;
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lane_n;
  logic              drive_q;
  logic [DATA_W-1:0] rd_q;

  assign en       = !stall;
  assign chip_sel = !sel0_n && sel1 && !sel2_n;

  zbt_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .chip_sel(chip_sel),
    .burst_next(burst_next), .op_read(op_read), .lane_wr_n(lane_wr_n),
    .addr(addr), .order_ilv(order_ilv),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_lane_n(s1_lane_n),
    .burst_act(burst_act), .beat_cnt(beat_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld    <= 1'b0;
      s2_wr     <= 1'b0;
      s2_addr   <= '0;
      s2_lane_n <= '1;
      drive_q   <= 1'b0;
    end else if (en) begin
      s2_vld    <= s1_vld;
      s2_wr     <= s1_wr;
      s2_addr   <= s1_addr;
      s2_lane_n <= s1_lane_n;
      drive_q   <= s1_vld && !s1_wr;
    end
  end

  zbt_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .en(en),
    .wr_vld(s2_vld && s2_wr), .wr_addr(s2_addr), .wr_lane_n(s2_lane_n), .wdata(wdata),
    .rd_vld(s1_vld && !s1_wr), .rd_addr(s1_addr), .rd_data(rd_q)
  );

  assign rdata_oe = drive_q && !drive_off;
  assign rdata    = rdata_oe ? rd_q : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              burst_next,
  input logic              drive_off,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic              s2_vld,
  input logic              s2_wr,
  input logic              drive_q,
  input logic              burst_act,
  input logic [1:0]        beat_cnt
);
  a_r1_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s1_vld && !s1_wr) |=> drive_q);

  a_r8_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !s1_vld) |=> !drive_q);

  a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> !(s2_vld && s2_wr));

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(drive_q) && $stable(s2_vld) && $stable(beat_cnt) && $stable(burst_act)));

  a_r5_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && burst_next && burst_act) |=> (beat_cnt == $past(beat_cnt) + 2'd1));

  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  a_r10_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    drive_off |-> !rdata_oe);
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .burst_next(burst_next),
  .drive_off(drive_off), .rdata_oe(rdata_oe), .rdata(rdata),
  .s1_vld(s1_vld), .s1_wr(s1_wr), .s2_vld(s2_vld), .s2_wr(s2_wr),
  .drive_q(drive_q), .burst_act(burst_act), .beat_cnt(beat_cnt)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = NL * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic burst_next = 1'b0, op_read = 1'b1, order_ilv = 1'b0, drive_off = 1'b0;
  logic [NL-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .burst_next(burst_next), .op_read(op_read),
    .lane_wr_n(lane_wr_n), .addr(addr), .order_ilv(order_ilv),
    .drive_off(drive_off), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // Behavioural reference
  typedef struct { bit rd; int a; bit [NL-1:0] ln; int due; } pend_t;
  pend_t pq[$];
  logic [DW-1:0] ref_mem [1 << AW];
  int  edge_n = 0;
  bit  m_act = 0, m_rd = 0;
  int  m_base = 0, m_cnt = 0;
  bit  exp_drive = 0;
  logic [DW-1:0] exp_data = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R11";

  task automatic model_edge();
    pend_t keep[$];
    bit sel;
    edge_n++;
    foreach (pq[i])
      if (pq[i].due == edge_n && !pq[i].rd)
        for (int b = 0; b < NL; b++)
          if (!pq[i].ln[b]) ref_mem[pq[i].a][8*b +: 8] = wdata[8*b +: 8];
    exp_drive = 0;
    foreach (pq[i])
      if (pq[i].due == edge_n && pq[i].rd) begin
        exp_drive = 1;
        exp_data  = ref_mem[pq[i].a];
      end
    foreach (pq[i]) if (pq[i].due > edge_n) keep.push_back(pq[i]);
    pq = keep;
    sel = !sel0_n && sel1 && !sel2_n;
    if (!burst_next) begin
      m_act = sel;
      if (sel) begin
        m_base = int'(addr); m_cnt = 0; m_rd = op_read;
        pq.push_back('{op_read, int'(addr), lane_wr_n, op_read ? edge_n + 1 : edge_n + 2});
      end
    end else if (m_act) begin
      int a;
      m_cnt = (m_cnt + 1) % 4;
      a = (m_base & ~3) | (order_ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4));
      pq.push_back('{m_rd, a, lane_wr_n, m_rd ? edge_n + 1 : edge_n + 2});
    end
  endtask

  task automatic compare();
    bit eo;
    logic [DW-1:0] ed;
    eo = exp_drive && !drive_off;
    ed = eo ? exp_data : '0;
    n_chk++;
    if (rdata_oe !== eo || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", cur_req, rdata_oe, rdata, eo, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (!stall && rst_n) model_edge();
    @(negedge clk);
    compare();
    wdata = $urandom;
  endtask

  task automatic cmd_load(input bit rd, input int a, input bit [NL-1:0] ln);
    burst_next = 0; op_read = rd; addr = AW'(a); lane_wr_n = ln;
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    tick();
  endtask

  task automatic cmd_adv(input bit [NL-1:0] ln);
    burst_next = 1; lane_wr_n = ln; op_read = $urandom; addr = AW'($urandom);
    tick();
  endtask

  task automatic cmd_desel(input int which);
    burst_next = 0; op_read = $urandom; addr = AW'($urandom);
    sel0_n = (which == 0); sel1 = (which != 1); sel2_n = (which == 2);
    tick();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 50000) begin
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected end before %0d cycles", wd);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    compare();
    rst_n = 1;
    tick();

    // Preload every word with a full-width write
    cur_req = "R2";
    for (int a = 0; a < (1 << AW); a++) cmd_load(0, a, '0);
    cmd_desel(0); cmd_desel(1);

    cur_req = "R1";
    for (int a = 0; a < 8; a++) cmd_load(1, a, '1);
    cmd_desel(2); cmd_desel(0);

    cur_req = "R9";
    cmd_load(0, 5, 4'b1010);
    cmd_load(0, 7, 4'b0111);
    cmd_desel(1); cmd_desel(1);
    cmd_load(1, 5, '1); cmd_load(1, 7, '1);
    cmd_desel(0); cmd_desel(0);

    cur_req = "R3";
    cmd_load(0, 10, '0); cmd_load(1, 10, '1);
    cmd_load(0, 10, 4'b1110); cmd_load(1, 10, '1);
    cmd_load(1, 11, '1); cmd_load(0, 11, 4'b0101);
    cmd_load(0, 12, '0); cmd_load(1, 11, '1); cmd_load(1, 12, '1);
    cmd_desel(2); cmd_desel(2);

    cur_req = "R5";
    order_ilv = 0;
    cmd_load(1, 6, '1); cmd_adv('1); cmd_adv('1); cmd_adv('1);
    cmd_load(0, 9, 4'b0000); cmd_adv(4'b1100); cmd_adv(4'b0011); cmd_adv(4'b0000);
    cmd_load(1, 9, '1); cmd_adv('1); cmd_adv('1); cmd_adv('1); cmd_adv('1);
    cmd_desel(0); cmd_desel(0);

    cur_req = "R6";
    order_ilv = 1;
    cmd_load(1, 11, '1); cmd_adv('1); cmd_adv('1); cmd_adv('1);
    cmd_load(0, 13, 4'b0000); cmd_adv(4'b0000); cmd_adv(4'b1001); cmd_adv(4'b0000);
    cmd_load(1, 13, '1); cmd_adv('1); cmd_adv('1); cmd_adv('1);
    cmd_desel(1); cmd_desel(1);

    cur_req = "R4";
    order_ilv = 0;
    cmd_load(1, 20, '1);
    stall = 1;
    for (int k = 0; k < 3; k++) cmd_load(0, 21 + k, '0);
    stall = 0;
    cmd_adv('1);
    stall = 1;
    cmd_desel(0); cmd_load(1, 33, '1);
    stall = 0;
    cmd_adv('1); cmd_desel(0); cmd_desel(0);

    cur_req = "R7";
    cmd_load(0, 30, '0); cmd_desel(1); cmd_desel(2);
    cmd_load(1, 30, '1); cmd_desel(0); cmd_desel(0);

    cur_req = "R8";
    cmd_desel(0); cmd_adv('1); cmd_adv('0); cmd_adv('1); cmd_desel(2);

    cur_req = "R10";
    cmd_load(1, 1, '1); cmd_desel(0);
    drive_off = 1; #1; compare();
    drive_off = 0; #1; compare();
    cmd_desel(0);

    cur_req = "R3";
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      stall = ($urandom_range(0, 9) == 0);
      drive_off = ($urandom_range(0, 15) == 0);
      if (k % 150 == 0) order_ilv = ~order_ilv;
      if (r < 10) cmd_desel($urandom_range(0, 2));
      else if (r < 40) cmd_adv(NL'($urandom));
      else cmd_load($urandom_range(0, 1), $urandom_range(0, (1 << AW) - 1), NL'($urandom));
    end
    stall = 0; drive_off = 0;
    cmd_desel(0); cmd_desel(0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule